// File: doc/BRIEF.md
# Flat Pointer Aperture Detector

This block sits in the address path of flat vector-memory operations. Each cycle it may take one pointer with the addressing-mode bits of the issuing context. It compares the pointer against two programmed windows: one for on-chip shared memory and one for per-thread private scratch memory. It then reports which of three targets the request belongs to (shared, private or the ordinary global path), together with the byte offset of the pointer inside the window it hit. The result is registered and appears one cycle after the request.

Two mode bits select how the window registers are read. With the translation-select bit low, the context always uses 64-bit pointers. With that bit high, a second bit picks 32-bit or 64-bit pointers. In the 64-bit modes each window is 4 GB wide and must sit in the unused middle region of the 64-bit space. In 32-bit mode each window is a 64 KB block that may be placed anywhere in the 32-bit space except at address zero, and a zero base switches that window off. Each base register holds address bits [63:16]. The low 16 bits of an effective base are always zero and the low 16 bits of an effective limit are always ones.

Top module: `flat_ape_detect`

## Requirements
- R1: After reset `out_valid` is 0, `out_sel` is 3'b001 (global), `out_offset` is 0 and `out_cfg_err` is 0.
- R2: `out_valid` follows `in_valid` one clock later. The other outputs change only in the cycle after an accepted request and otherwise hold their values.
- R3: When `out_valid` is 1, `out_sel` is one-hot: bit 0 = global, bit 1 = shared, bit 2 = private.
- R4: In 32-bit mode (`in_atc`=1, `in_ptr32`=1) only `in_ptr[31:0]` is compared. A window covers {base bits [31:16], 16'h0000} through {base bits [31:16], 16'hFFFF}, and both ends are inside.
- R5: In 32-bit mode a window whose base bits [31:16] are zero never hits.
- R6: In the 64-bit modes a window covers {base bits [63:32], 32'h0} through {base bits [63:32], 32'hFFFFFFFF}, and both ends are inside. Base bits [31:16] are not used in these modes.
- R7: In the 64-bit modes a window whose effective base has bits [63:47] all zeros or all ones never hits.
- R8: On a hit, `out_offset` is the pointer minus the effective base of the hit window, truncated to 32 bits. On a global result it is 0.
- R9: If both windows hit, the result is shared and `out_cfg_err` is 1. In every other case `out_cfg_err` is 0.
- R10: When `in_atc` is 0, `in_ptr32` is ignored and 64-bit mode applies.
- R11: A pointer that hits no enabled window gives the global result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request qualifier |
| in_ptr | input | 64 | Flat pointer |
| in_atc | input | 1 | Translation-select mode bit |
| in_ptr32 | input | 1 | 32-bit pointer select; meaningful only when `in_atc` is 1 |
| shared_base | input | 48 | Shared window base, address bits [63:16] |
| private_base | input | 48 | Private window base, address bits [63:16] |
| out_valid | output | 1 | Result qualifier |
| out_sel | output | 3 | One-hot target: bit 0 global, bit 1 shared, bit 2 private |
| out_offset | output | 32 | Offset inside the hit window |
| out_cfg_err | output | 1 | Both windows hit at once |

## Verification
Correct software never programs two overlapping windows, so the priority path and the configuration error cannot be reached through normal use. The stimulus table reaches them on purpose by giving both windows the same base, once in 32-bit mode and once in 64-bit mode. The window edges are also hard to hit by chance. The table places pointers exactly on the first and last byte of each window and one byte past the end. It also includes a pointer whose upper word would matter if `in_ptr32` were wrongly obeyed while `in_atc` is low.

// File: rtl/flat_ape_pkg.sv
package flat_ape_pkg;

   typedef enum logic [1:0] {
      FA_MODE_WIDE_VM  = 2'd0,
      FA_MODE_WIDE_SYS = 2'd1,
      FA_MODE_NARROW   = 2'd2
   } fa_mode_e;

   localparam int FA_SEL_GLOBAL = 0;
   localparam int FA_SEL_SHARED = 1;
   localparam int FA_SEL_PRIV   = 2;

   function automatic logic fa_is_narrow(fa_mode_e m);
      return (m == FA_MODE_NARROW);
   endfunction

endpackage

// File: rtl/flat_ape_mode_dec.sv
module flat_ape_mode_dec
   import flat_ape_pkg::*;
#(
   parameter int ADDR_W   = 64,
   parameter int NARROW_W = 32
)(
   input  logic              atc,
   input  logic              ptr32,
   input  logic [ADDR_W-1:0] ptr_in,
   output fa_mode_e          mode,
   output logic              narrow,
   output logic [ADDR_W-1:0] ptr_eff
);

   generate
      if (NARROW_W >= ADDR_W) begin : g_bad_narrow
         $error("NARROW_W must be below ADDR_W");
      end
   endgenerate

   // R10: ptr32 only counts when the translation-select bit is set
   always_comb begin
      if (!atc)       mode = FA_MODE_WIDE_VM;
      else if (ptr32) mode = FA_MODE_NARROW;
      else            mode = FA_MODE_WIDE_SYS;
   end

   assign narrow = fa_is_narrow(mode);

   // R4: upper pointer word is dropped in narrow mode
   assign ptr_eff = narrow ? {{(ADDR_W-NARROW_W){1'b0}}, ptr_in[NARROW_W-1:0]} : ptr_in;

endmodule

// File: rtl/flat_ape_window.sv
module flat_ape_window #(
   parameter int ADDR_W      = 64,
   parameter int GRAN_W      = 16,
   parameter int NARROW_W    = 32,
   parameter int WIDE_SPAN_W = 32,
   parameter int CANON_W     = 48,
   parameter int OFS_W       = 32
)(
   input  logic                     narrow,
   input  logic [ADDR_W-1:0]        ptr,
   input  logic [ADDR_W-GRAN_W-1:0] base_reg,
   output logic                     hit,
   output logic [OFS_W-1:0]         offset
);

   localparam int RW       = ADDR_W - GRAN_W;
   localparam int N_FLD_W  = NARROW_W - GRAN_W;
   localparam int W_FLD_LO = WIDE_SPAN_W - GRAN_W;
   localparam int HOLE_LO  = CANON_W - 1;
   localparam int HOLE_W   = ADDR_W - HOLE_LO;

   generate
      if (WIDE_SPAN_W <= GRAN_W || WIDE_SPAN_W >= ADDR_W) begin : g_bad_span
         $error("WIDE_SPAN_W out of range");
      end
      if (GRAN_W >= NARROW_W) begin : g_bad_gran
         $error("GRAN_W must be below NARROW_W");
      end
      if (CANON_W <= WIDE_SPAN_W || CANON_W >= ADDR_W) begin : g_bad_canon
         $error("CANON_W out of range");
      end
      if (OFS_W < WIDE_SPAN_W || OFS_W > ADDR_W) begin : g_bad_ofs
         $error("OFS_W must cover the wide span");
      end
   endgenerate

   logic [ADDR_W-1:0] n_base, n_limit, w_base, w_limit;
   logic [ADDR_W-1:0] eff_base, eff_limit, diff;
   logic              n_en, w_en, en;
   logic [HOLE_W-1:0] hole_bits;

   // narrow: 64 KB block, disabled by a zero field (R4, R5)
   assign n_base  = {{(ADDR_W-NARROW_W){1'b0}}, base_reg[N_FLD_W-1:0], {GRAN_W{1'b0}}};
   assign n_limit = {{(ADDR_W-NARROW_W){1'b0}}, base_reg[N_FLD_W-1:0], {GRAN_W{1'b1}}};
   assign n_en    = |base_reg[N_FLD_W-1:0];

   // wide: span-aligned window that must lie in the hole (R6, R7)
   assign w_base    = {base_reg[RW-1:W_FLD_LO], {WIDE_SPAN_W{1'b0}}};
   assign w_limit   = {base_reg[RW-1:W_FLD_LO], {WIDE_SPAN_W{1'b1}}};
   assign hole_bits = w_base[ADDR_W-1:HOLE_LO];
   assign w_en      = (|hole_bits) && !(&hole_bits);

   assign eff_base  = narrow ? n_base  : w_base;
   assign eff_limit = narrow ? n_limit : w_limit;
   assign en        = narrow ? n_en    : w_en;

   assign hit    = en && (ptr >= eff_base) && (ptr <= eff_limit);
   assign diff   = ptr - eff_base;
   assign offset = diff[OFS_W-1:0];

endmodule

// File: rtl/flat_ape_arb.sv
module flat_ape_arb #(
   parameter int NUM_APE = 2,
   parameter int OFS_W   = 32
)(
   input  logic [NUM_APE-1:0]            hit,
   input  logic [NUM_APE-1:0][OFS_W-1:0] ofs,
   output logic [NUM_APE:0]              sel,
   output logic [OFS_W-1:0]              offset,
   output logic                          multi
);

   generate
      if (NUM_APE < 1) begin : g_bad_num
         $error("NUM_APE must be at least 1");
      end
   endgenerate

   logic found;

   // lowest index wins (shared first), bit 0 is the global target
   always_comb begin
      sel    = '0;
      offset = '0;
      found  = 1'b0;
      for (int i = 0; i < NUM_APE; i++) begin
         if (hit[i] && !found) begin
            sel[i+1] = 1'b1;
            offset   = ofs[i];
            found    = 1'b1;
         end
      end
      if (!found) sel[0] = 1'b1;
      multi = ($countones(hit) > 1);
   end

endmodule

// File: rtl/flat_ape_detect.sv
module flat_ape_detect
   import flat_ape_pkg::*;
#(
   parameter int ADDR_W      = 64,
   parameter int GRAN_W      = 16,
   parameter int NARROW_W    = 32,
   parameter int WIDE_SPAN_W = 32,
   parameter int CANON_W     = 48,
   parameter int OFS_W       = 32
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [ADDR_W-1:0]        in_ptr,
   input  logic                     in_atc,
   input  logic                     in_ptr32,
   input  logic [ADDR_W-GRAN_W-1:0] shared_base,
   input  logic [ADDR_W-GRAN_W-1:0] private_base,
   output logic                     out_valid,
   output logic [2:0]               out_sel,
   output logic [OFS_W-1:0]         out_offset,
   output logic                     out_cfg_err
);

   localparam int NUM_APE = 2;
   localparam int RW      = ADDR_W - GRAN_W;

   fa_mode_e                      mode;
   logic                          narrow;
   logic [ADDR_W-1:0]             ptr_eff;
   logic [NUM_APE-1:0][RW-1:0]    bases;
   logic [NUM_APE-1:0]            hits;
   logic [NUM_APE-1:0][OFS_W-1:0] offs;
   logic [NUM_APE:0]              sel_d;
   logic [OFS_W-1:0]              off_d;
   logic                          err_d;

   assign bases[FA_SEL_SHARED-1] = shared_base;
   assign bases[FA_SEL_PRIV-1]   = private_base;

   flat_ape_mode_dec #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) i_mode (
      .atc    (in_atc),
      .ptr32  (in_ptr32),
      .ptr_in (in_ptr),
      .mode   (mode),
      .narrow (narrow),
      .ptr_eff(ptr_eff)
   );

   generate
      for (genvar g = 0; g < NUM_APE; g++) begin : g_win
         flat_ape_window #(
            .ADDR_W(ADDR_W), .GRAN_W(GRAN_W), .NARROW_W(NARROW_W),
            .WIDE_SPAN_W(WIDE_SPAN_W), .CANON_W(CANON_W), .OFS_W(OFS_W)
         ) i_win (
            .narrow  (narrow),
            .ptr     (ptr_eff),
            .base_reg(bases[g]),
            .hit     (hits[g]),
            .offset  (offs[g])
         );
      end
   endgenerate

   flat_ape_arb #(.NUM_APE(NUM_APE), .OFS_W(OFS_W)) i_arb (
      .hit   (hits),
      .ofs   (offs),
      .sel   (sel_d),
      .offset(off_d),
      .multi (err_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_sel     <= 3'b001;
         out_offset  <= '0;
         out_cfg_err <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_sel     <= sel_d;
            out_offset  <= off_d;
            out_cfg_err <= err_d;
         end
      end
   end

endmodule

// File: rtl/flat_ape_detect_chk.sv
module flat_ape_detect_chk #(
   parameter int ADDR_W   = 64,
   parameter int GRAN_W   = 16,
   parameter int NARROW_W = 32,
   parameter int OFS_W    = 32
)(
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_valid,
   input logic                     in_atc,
   input logic                     in_ptr32,
   input logic [ADDR_W-GRAN_W-1:0] shared_base,
   input logic [ADDR_W-GRAN_W-1:0] private_base,
   input logic                     out_valid,
   input logic [2:0]               out_sel,
   input logic [OFS_W-1:0]         out_offset,
   input logic                     out_cfg_err
);

   localparam int N_FLD_W = NARROW_W - GRAN_W;

   p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_sel) && $stable(out_offset) && $stable(out_cfg_err)));

   p_onehot_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($countones(out_sel) == 1));

   p_narrow_span_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_atc && in_ptr32) |=> (out_sel[0] || ((out_offset >> GRAN_W) == '0)));

   p_narrow_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_atc && in_ptr32 && (shared_base[N_FLD_W-1:0] == '0)
       && (private_base[N_FLD_W-1:0] == '0)) |=> out_sel[0]);

   p_global_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_sel[0]) |-> (out_offset == '0));

   p_err_shared_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_cfg_err) |-> out_sel[1]);

endmodule

bind flat_ape_detect flat_ape_detect_chk #(
   .ADDR_W(ADDR_W), .GRAN_W(GRAN_W), .NARROW_W(NARROW_W), .OFS_W(OFS_W)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_atc      (in_atc),
   .in_ptr32    (in_ptr32),
   .shared_base (shared_base),
   .private_base(private_base),
   .out_valid   (out_valid),
   .out_sel     (out_sel),
   .out_offset  (out_offset),
   .out_cfg_err (out_cfg_err)
);

// File: tb/test_flat_ape_detect.sv
`timescale 1ns/1ps
module test_flat_ape_detect;

   typedef struct packed {
      logic        atc;
      logic        p32;
      logic [63:0] ptr;
      logic [47:0] sb;
      logic [47:0] pb;
      logic [2:0]  sel;
      logic [31:0] off;
      logic        err;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      // R4 narrow: first byte of shared block
      '{1'b1, 1'b1, 64'h0000_0000_0001_0000, 48'h1, 48'h3, 3'b010, 32'h0000_0000, 1'b0, 8'd4},
      // R4 narrow: last byte of shared block
      '{1'b1, 1'b1, 64'h0000_0000_0001_FFFF, 48'h1, 48'h3, 3'b010, 32'h0000_FFFF, 1'b0, 8'd4},
      // R11 one past the end -> global
      '{1'b1, 1'b1, 64'h0000_0000_0002_0000, 48'h1, 48'h3, 3'b001, 32'h0000_0000, 1'b0, 8'd11},
      // R4 upper word ignored, private hit
      '{1'b1, 1'b1, 64'hFFFF_FFFF_0003_1234, 48'h1, 48'h3, 3'b100, 32'h0000_1234, 1'b0, 8'd4},
      // R5 zero private base disables it
      '{1'b1, 1'b1, 64'h0000_0000_0000_0005, 48'h1, 48'h0, 3'b001, 32'h0000_0000, 1'b0, 8'd5},
      // R9 narrow overlap -> shared + error
      '{1'b1, 1'b1, 64'h0000_0000_0001_0010, 48'h1, 48'h1, 3'b010, 32'h0000_0010, 1'b1, 8'd9},
      // R6 wide: first byte
      '{1'b1, 1'b0, 64'h0001_0000_0000_0000, 48'h0001_0000_0000, 48'h0002_0000_0000, 3'b010, 32'h0000_0000, 1'b0, 8'd6},
      // R6 wide: last byte
      '{1'b1, 1'b0, 64'h0001_0000_FFFF_FFFF, 48'h0001_0000_0000, 48'h0002_0000_0000, 3'b010, 32'hFFFF_FFFF, 1'b0, 8'd6},
      // R6 wide: one past the end
      '{1'b1, 1'b0, 64'h0001_0001_0000_0000, 48'h0001_0000_0000, 48'h0002_0000_0000, 3'b001, 32'h0000_0000, 1'b0, 8'd6},
      // R10 atc low, ptr32 ignored -> wide private, R8 offset
      '{1'b0, 1'b1, 64'h0002_0000_1234_5678, 48'h0001_0000_0000, 48'h0002_0000_0000, 3'b100, 32'h1234_5678, 1'b0, 8'd10},
      // R7 base with high bits all zero is disabled
      '{1'b1, 1'b0, 64'h0000_0001_0000_0010, 48'h0000_0001_0000, 48'h0002_0000_0000, 3'b001, 32'h0000_0000, 1'b0, 8'd7},
      // R7 base with high bits all ones is disabled
      '{1'b0, 1'b0, 64'hFFFF_FFFF_0000_0000, 48'hFFFF_FFFF_0000, 48'h0002_0000_0000, 3'b001, 32'h0000_0000, 1'b0, 8'd7},
      // R9 wide overlap -> shared + error
      '{1'b1, 1'b0, 64'h0001_0000_0000_0040, 48'h0001_0000_0000, 48'h0001_0000_0000, 3'b010, 32'h0000_0040, 1'b1, 8'd9},
      // R10 atc high + ptr32 -> narrow, wide bases have zero narrow field
      '{1'b1, 1'b1, 64'h0001_0000_0000_0000, 48'h0001_0000_0000, 48'h0002_0000_0000, 3'b001, 32'h0000_0000, 1'b0, 8'd10}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] in_ptr = '0;
   logic        in_atc = 1'b0;
   logic        in_ptr32 = 1'b0;
   logic [47:0] shared_base = '0;
   logic [47:0] private_base = '0;
   logic        out_valid;
   logic [2:0]  out_sel;
   logic [31:0] out_offset;
   logic        out_cfg_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   flat_ape_detect i_flat_ape_detect (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ptr(in_ptr),
      .in_atc(in_atc), .in_ptr32(in_ptr32), .shared_base(shared_base),
      .private_base(private_base), .out_valid(out_valid), .out_sel(out_sel),
      .out_offset(out_offset), .out_cfg_err(out_cfg_err)
   );

   task automatic check(input string req, input logic v, input logic [2:0] s,
                        input logic [31:0] o, input logic e);
      checks++;
      if (out_valid !== v || out_sel !== s || out_offset !== o || out_cfg_err !== e) begin
         errors++;
         $display("FAIL %s: got valid=%b sel=%b off=%h err=%b, expected valid=%b sel=%b off=%h err=%b",
                  req, out_valid, out_sel, out_offset, out_cfg_err, v, s, o, e);
      end
   endtask

   task automatic drive(input vec_t t, input logic v);
      in_atc       = t.atc;
      in_ptr32     = t.p32;
      in_ptr       = t.ptr;
      shared_base  = t.sb;
      private_base = t.pb;
      in_valid     = v;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", 1'b0, 3'b001, 32'h0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 1'b0, 3'b001, 32'h0, 1'b0);

      // table walk, R3 one-hot checked in every row
      for (int i = 0; i < NV; i++) begin
         drive(VECS[i], 1'b1);
         @(negedge clk);
         in_valid = 1'b0;
         check($sformatf("R%0d row %0d", VECS[i].req, i), 1'b1, VECS[i].sel, VECS[i].off, VECS[i].err);
      end

      // R2 hold: idle request with a hitting pointer leaves result unchanged
      drive(VECS[0], 1'b1);
      @(negedge clk);
      drive(VECS[3], 1'b0);
      @(negedge clk);
      check("R2 hold", 1'b0, 3'b010, 32'h0, 1'b0);
      @(negedge clk);
      check("R2 hold", 1'b0, 3'b010, 32'h0, 1'b0);

      // R2 back-to-back stream, R8 offsets
      drive(VECS[3], 1'b1);
      @(negedge clk);
      drive(VECS[7], 1'b1);
      check("R2 stream a", 1'b1, 3'b100, 32'h0000_1234, 1'b0);
      @(negedge clk);
      in_valid = 1'b0;
      check("R2 stream b", 1'b1, 3'b010, 32'hFFFF_FFFF, 1'b0);

      // R1 reset mid-run returns to idle state
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 rerst", 1'b0, 3'b001, 32'h0, 1'b0);
      rst_n = 1'b1;
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 200000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout, expected completion");
      end
      #1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule